// File: doc/BRIEF.md
# Double-Handshake Parallel Byte Receiver

This block receives bytes from a peripheral over an 8-bit parallel bus. The link uses a strobe driven by the sender and an acknowledge line driven back by this block. In the default four-phase exchange, the sender first pulls its strobe low to ask whether the receiver is ready. The receiver raises acknowledge once it has room for a byte. The sender then puts the byte on the bus and returns the strobe high, which marks the data as valid. The receiver captures the byte and lowers acknowledge to say that it has the data.

Each captured byte is handed to the local side through a valid/ready pair with room for one byte. The receiver does not offer readiness to the sender while that byte is still waiting to be taken.

A mode input selects a single-handshake variant. In that variant the byte is captured when the strobe is asserted low, and a one-cycle acknowledge pulse then releases the sender.

The strobe passes through a two-flop synchronizer. The bus is sampled one cycle after the synchronized strobe edge that qualifies it. In four-phase mode, a strobe returning high while acknowledge is low breaks the protocol. It raises a sticky error flag, and no byte is captured.

Top module: `hsByteRx`

## Requirements
- R1: While reset (rstN low) is applied, linkAck, outValid and protoErr are all 0.
- R2: In four-phase mode (modeSingle=0), with the output register empty, a falling linkStb raises linkAck on the third rising clock edge after the strobe change.
- R3: In four-phase mode, a rising linkStb while linkAck is 1 captures linkData. outValid becomes 1 with that byte, and linkAck becomes 0, on the fourth rising edge after the strobe change.
- R4: In four-phase mode, a strobe request that arrives while outValid is 1 does not raise linkAck. Acknowledge rises only after the local side has accepted the pending byte.
- R5: While outValid is 1 and outReady is 0, outValid stays 1 and outData does not change. A byte leaves on a clock edge where both outValid and outReady are 1.
- R6: In four-phase mode, a rising linkStb while linkAck is 0 sets protoErr to 1. protoErr then stays 1 until reset, and no byte is delivered for that exchange.
- R7: In single-handshake mode (modeSingle=1), a falling linkStb with the output register empty captures linkData. linkAck is then 1 for exactly one clock cycle, in the same cycle that the byte appears on outData.
- R8: In single-handshake mode, a falling linkStb that arrives while outValid is 1 is held back without acknowledge. The new byte is captured after the pending byte has been accepted.
- R9: Bytes reach outData in the order they were sent, each exactly once, under random delays between the phases on both sides.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSingle | input | 1 | 1 selects single-handshake exchange, 0 selects four-phase |
| linkStb | input | 1 | Strobe from the sender, asynchronous, idles high |
| linkData | input | 8 | Parallel data from the sender |
| linkAck | output | 1 | Acknowledge to the sender |
| outData | output | 8 | Captured byte toward the local side |
| outValid | output | 1 | outData holds a byte that has not been accepted |
| outReady | input | 1 | Local side accepts the byte this cycle |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
A controller stuck in the ready state, or a lost busy indication, shows up at the ports within a few cycles of the next strobe edge. Acknowledge then rises while outValid is still 1, or a byte overwrites one that has not been read, and the scoreboard sees that byte as missing or out of order at the next accept. A synchronizer edge detector that is off by a stage moves the acknowledge and valid edges by one cycle, which the exact-latency checks on the first exchange catch. A capture taken on the wrong strobe edge latches the byte left from the previous exchange, so the byte popped from the queue does not match.

// File: rtl/hsRxPkg.sv
package hsRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a strobe request
    ST_PEND,   // request seen, output register still busy
    ST_READY,  // acknowledge high, waiting for data-valid edge
    ST_CAPT,   // sample the bus this cycle
    ST_PULSE   // single-handshake acknowledge pulse
  } rxState_e;

  typedef struct packed {
    logic loadByte;
    logic ackRaise;
    logic ackDrop;
    logic errSet;
  } rxCtrl_t;

endpackage

// File: rtl/hsRxSync.sv
module hsRxSync #(
  parameter int STAGES = 2,
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic edgeRise,
  output logic edgeFall
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {CHAIN_W{IDLE_LEVEL}};
    else       chain <= {chain[CHAIN_W-2:0], asyncIn};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  assign edgeRise = chain[STAGES-1] & ~chain[STAGES];
  assign edgeFall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/hsRxCtrl.sv
module hsRxCtrl
  import hsRxPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeSingle,
  input  logic    stbRise,
  input  logic    stbFall,
  input  logic    busy,
  output rxCtrl_t ctrl
);
  rxState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (!modeSingle && stbRise) begin
          ctrl.errSet = 1'b1;
        end else if (stbFall) begin
          if (busy)            stateNext = ST_PEND;
          else if (modeSingle) stateNext = ST_CAPT;
          else begin
            ctrl.ackRaise = 1'b1;
            stateNext     = ST_READY;
          end
        end
      end
      ST_PEND: begin
        if (!modeSingle && stbRise) begin
          ctrl.errSet = 1'b1;
          stateNext   = ST_IDLE;
        end else if (!busy) begin
          if (modeSingle) stateNext = ST_CAPT;
          else begin
            ctrl.ackRaise = 1'b1;
            stateNext     = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (stbRise) stateNext = ST_CAPT;
      end
      ST_CAPT: begin
        ctrl.loadByte = 1'b1;
        if (modeSingle) begin
          ctrl.ackRaise = 1'b1;
          stateNext     = ST_PULSE;
        end else begin
          ctrl.ackDrop = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_PULSE: begin
        ctrl.ackDrop = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3: a four-phase capture only follows the ready state
  assert_capt_from_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPT && !modeSingle) |-> ($past(state) == ST_READY));

  // R4, R8: never load into an occupied output register
  assert_no_load_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadByte |-> !busy);

endmodule

// File: rtl/hsRxData.sv
module hsRxData
  import hsRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSingle,
  input  rxCtrl_t           ctrl,
  input  logic [DATA_W-1:0] linkData,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              ackOut,
  output logic              errOut
);
  logic [DATA_W-1:0] dataQ;
  logic              validQ, ackQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      validQ <= 1'b0;
      ackQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (ctrl.loadByte) begin
        dataQ  <= linkData;
        validQ <= 1'b1;
      end else if (validQ && outReady) begin
        validQ <= 1'b0;
      end
      if (ctrl.ackDrop)       ackQ <= 1'b0;
      else if (ctrl.ackRaise) ackQ <= 1'b1;
      if (ctrl.errSet) errQ <= 1'b1;
    end
  end

  assign outData  = dataQ;
  assign outValid = validQ;
  assign ackOut   = ackQ;
  assign errOut   = errQ;

  // R5: an unaccepted byte holds
  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !outReady) |=> (validQ && $stable(dataQ)));

  // R6: error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  // R4: four-phase readiness only with an empty output register
  assert_ack_when_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSingle && $rose(ackQ)) |-> !validQ);

  // R7: single-handshake acknowledge is a one-cycle pulse
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSingle && ackQ) |=> !ackQ);

endmodule

// File: rtl/hsByteRx.sv
module hsByteRx
  import hsRxPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSingle,
  input  logic              linkStb,
  input  logic [DATA_W-1:0] linkData,
  output logic              linkAck,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              protoErr
);
  logic    stbRise, stbFall;
  rxCtrl_t ctrl;

  hsRxSync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(linkStb),
    .edgeRise(stbRise), .edgeFall(stbFall)
  );

  hsRxCtrl uCtrl (
    .clk(clk), .rstN(rstN), .modeSingle(modeSingle),
    .stbRise(stbRise), .stbFall(stbFall), .busy(outValid), .ctrl(ctrl)
  );

  hsRxData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .modeSingle(modeSingle), .ctrl(ctrl),
    .linkData(linkData), .outReady(outReady), .outData(outData),
    .outValid(outValid), .ackOut(linkAck), .errOut(protoErr)
  );

endmodule

// File: tb/sim_hsByteRx.sv
module sim_hsByteRx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSingle = 1'b0;
  logic       linkStb = 1'b1;
  logic [7:0] linkData = 8'h00;
  logic       linkAck;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;
  logic       protoErr;

  int checks = 0;
  int failures = 0;
  int readyMode = 0;  // 0 hold low, 1 hold high, 2 random
  logic [7:0] expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  hsByteRx u0 (
    .clk(clk), .rstN(rstN), .modeSingle(modeSingle), .linkStb(linkStb),
    .linkData(linkData), .linkAck(linkAck), .outData(outData),
    .outValid(outValid), .outReady(outReady), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic       stall = 1'b0;
    logic [7:0] heldData = 8'h00;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        stall = 1'b0;
        outReady = 1'b0;
      end else begin
        if (stall) begin
          check(outValid == 1'b1, "R5 valid hold", outValid, 1);
          check(outData == heldData, "R5 data hold", outData, heldData);
        end
        if (readyMode == 0)      outReady = 1'b0;
        else if (readyMode == 1) outReady = 1'b1;
        else                     outReady = 1'($urandom_range(0, 1));
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R9 unexpected byte", outData, 0);
          end else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(outData == e, "R9 byte order", outData, e);
          end
        end
        stall = outValid && !outReady;
        heldData = outData;
      end
    end
  end

  task automatic doReset(input logic single);
    rstN = 1'b0;
    linkStb = 1'b1;
    modeSingle = single;
    repeat (3) @(negedge clk);
    check(linkAck == 1'b0, "R1 ack", linkAck, 0);
    check(outValid == 1'b0, "R1 valid", outValid, 0);
    check(protoErr == 1'b0, "R1 err", protoErr, 0);
    expQ.delete();
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendDouble(input logic [7:0] b);
    linkStb = 1'b0;
    do @(negedge clk); while (!linkAck);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    linkData = b;
    expQ.push_back(b);
    linkStb = 1'b1;
    do @(negedge clk); while (linkAck);
    repeat ($urandom_range(1, 4)) @(negedge clk);
  endtask

  task automatic sendSingle(input logic [7:0] b);
    linkData = b;
    expQ.push_back(b);
    linkStb = 1'b0;
    do @(negedge clk); while (!linkAck);
    @(negedge clk);
    check(linkAck == 1'b0, "R7 pulse width", linkAck, 0);
    linkStb = 1'b1;
    repeat ($urandom_range(3, 6)) @(negedge clk);
  endtask

  task automatic drain();
    readyMode = 1;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 all delivered", expQ.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset, R2 / R3 exact latency
    doReset(1'b0);
    readyMode = 1;
    linkStb = 1'b0;
    repeat (2) @(negedge clk);
    check(linkAck == 1'b0, "R2 ack not early", linkAck, 0);
    @(negedge clk);
    check(linkAck == 1'b1, "R2 ack raised", linkAck, 1);
    linkData = 8'hA5;
    expQ.push_back(8'hA5);
    linkStb = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R3 valid not early", outValid, 0);
    check(linkAck == 1'b1, "R3 ack still high", linkAck, 1);
    @(negedge clk);
    check(outValid == 1'b1, "R3 valid", outValid, 1);
    check(outData == 8'hA5, "R3 data", outData, 8'hA5);
    check(linkAck == 1'b0, "R3 ack dropped", linkAck, 0);
    repeat (3) @(negedge clk);
    drain();

    // R4: request held while busy, then released
    readyMode = 0;
    sendDouble(8'h3C);
    linkStb = 1'b0;
    repeat (8) @(negedge clk);
    check(linkAck == 1'b0, "R4 no ack while busy", linkAck, 0);
    check(outData == 8'h3C, "R5 data kept", outData, 8'h3C);
    readyMode = 1;
    do @(negedge clk); while (!linkAck);
    readyMode = 0;
    check(outValid == 1'b0, "R4 ack after accept", outValid, 0);
    linkData = 8'hC3;
    expQ.push_back(8'hC3);
    linkStb = 1'b1;
    do @(negedge clk); while (linkAck);
    repeat (2) @(negedge clk);
    drain();

    // R6: data-valid edge without acknowledge
    readyMode = 0;
    sendDouble(8'h77);
    linkStb = 1'b0;
    repeat (6) @(negedge clk);
    linkData = 8'h99;
    linkStb = 1'b1;
    repeat (6) @(negedge clk);
    check(protoErr == 1'b1, "R6 error set", protoErr, 1);
    check(linkAck == 1'b0, "R6 ack low", linkAck, 0);
    drain();
    repeat (6) @(negedge clk);
    check(outValid == 1'b0, "R6 no byte captured", outValid, 0);
    check(protoErr == 1'b1, "R6 error sticky", protoErr, 1);

    // R9 four-phase random traffic
    doReset(1'b0);
    readyMode = 2;
    for (int i = 0; i < 40; i++) sendDouble(8'($urandom));
    drain();
    check(protoErr == 1'b0, "R6 no false error", protoErr, 0);

    // R7 single-handshake, R8 busy hold-off
    doReset(1'b1);
    readyMode = 0;
    sendSingle(8'h5A);
    check(outValid == 1'b1 && outData == 8'h5A, "R7 byte captured", outData, 8'h5A);
    linkData = 8'hE1;
    expQ.push_back(8'hE1);
    linkStb = 1'b0;
    repeat (8) @(negedge clk);
    check(linkAck == 1'b0, "R8 no ack while busy", linkAck, 0);
    check(outData == 8'h5A, "R8 old byte kept", outData, 8'h5A);
    readyMode = 1;
    do @(negedge clk); while (!linkAck);
    check(outData == 8'hE1, "R8 new byte captured", outData, 8'hE1);
    linkStb = 1'b1;
    repeat (4) @(negedge clk);
    drain();

    readyMode = 2;
    for (int i = 0; i < 30; i++) sendSingle(8'($urandom));
    drain();
    check(protoErr == 1'b0, "R7 no error in single mode", protoErr, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule